// File: doc/BRIEF.md
# Table Lookup Execute Unit with Gated Carry Load

This block carries out the execute stage of the table-reference instruction in a small 4-bit controller core. When the decoder strobes a table read, the block forms a ROM address from a 6-bit page operand and two 4-bit data registers. In the same cycle it asks the return stack to save the program counter and starts a read on the synchronous ROM. In the next cycle it writes the low eight bits of the returned 9-bit word into the two data registers as two nibbles. It then asks the return stack to restore the program counter.

The ninth ROM bit is passed to the carry flag only while a one-way enable flag is set. A dedicated instruction strobe sets this flag. No instruction can clear it. Only system reset or a return from RAM back-up mode clears it. While the flag is clear, the ninth bit is dropped and the carry flag keeps its value.

Top module: `tbl_lookup`

## Requirements
- R1: While rst_ni is low, every write strobe and stack request is low, busy_o is low and the carry enable flag is cleared. A table read that follows reset does not write carry.
- R2: When tabp_i is high and busy_o is low, rom_re_o and stk_push_o are high in that same cycle. rom_addr_o is then {page_i, hi_nib_i, lo_nib_i}: the page is in bits 13:8, the high register in bits 7:4 and the low register in bits 3:0. When no table read is issued, rom_re_o, stk_push_o and reg_we_o stay low.
- R3: In the cycle after a table read is issued, reg_we_o and stk_pop_o are high. lo_wdata_o equals ROM bits 3:0 and hi_wdata_o equals ROM bits 7:4.
- R4: When the enable flag is 1 in the write cycle, cy_we_o is high and cy_o equals ROM bit 8.
- R5: When the enable flag is 0 in the write cycle, cy_we_o and cy_o are both low, so ROM bit 8 has no effect and carry is left unchanged.
- R6: A high en_set_i sets the enable flag from the next cycle onward. A table read issued in the same cycle as the set already loads carry in its write cycle.
- R7: A high bkup_ret_i clears the enable flag from the next cycle onward. It takes priority over en_set_i in the same cycle.
- R8: Once set, the enable flag stays set across any number of table reads and idle cycles until reset or bkup_ret_i.
- R9: A table read occupies two cycles. busy_o is high only in the write cycle. A tabp_i strobe in that cycle is ignored: it produces no ROM read and no stack push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| tabp_i | input | 1 | Decoded table-reference instruction strobe |
| en_set_i | input | 1 | Decoded strobe that sets the carry load enable |
| bkup_ret_i | input | 1 | Return-from-RAM-back-up event, clears the enable |
| page_i | input | 6 | Page operand of the table instruction |
| hi_nib_i | input | 4 | High data register, middle address bits |
| lo_nib_i | input | 4 | Low data register, lowest address bits |
| rom_rdata_i | input | 9 | ROM word, valid the cycle after the read |
| rom_re_o | output | 1 | ROM read enable |
| rom_addr_o | output | 14 | ROM read address |
| stk_push_o | output | 1 | Request to save the program counter |
| stk_pop_o | output | 1 | Request to restore the program counter |
| busy_o | output | 1 | High during the write cycle of a table read |
| reg_we_o | output | 1 | Write strobe for both data registers |
| hi_wdata_o | output | 4 | Data for the high register |
| lo_wdata_o | output | 4 | Data for the low register |
| cy_we_o | output | 1 | Carry flag write strobe |
| cy_o | output | 1 | Carry flag write value |

## Verification
Random table reads with random page and register operands check that each address field lands in its own bit range, so a swapped or shifted field shows up. The ROM words vary bit 8, and reads are run with the flag clear, with the flag set, and in the very cycle the flag is set. These three cases separate a missing gate, an inverted gate and a wrong flag-update cycle. Directed cases put set and back-up-return strobes in the same cycle, which shows the priority between them. Other directed cases raise tabp_i during the write cycle and apply reset in the middle of a run, which shows that a second read cannot start early and that the flag is cleared.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int unsigned PAGE_W_DEF = 6;
  localparam int unsigned NIB_W_DEF  = 4;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } tbl_state_e;
endpackage

// File: rtl/tbl_cy_enable.sv
module tbl_cy_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q;

  // clear has priority over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (clr_i)  en_q <= 1'b0;
    else if (set_i)  en_q <= 1'b1;
  end

  assign en_o = en_q;

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> en_q);
  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !en_q);
  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !clr_i) |=> en_q);
endmodule

// File: rtl/tbl_addr_gen.sv
module tbl_addr_gen #(
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned NIB_W  = 4
) (
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [NIB_W-1:0]          hi_i,
  input  logic [NIB_W-1:0]          lo_i,
  output logic [PAGE_W+2*NIB_W-1:0] addr_o
);
  assign addr_o = {page_i, hi_i, lo_i};
endmodule

// File: rtl/tbl_seq.sv
module tbl_seq
  import tbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o,
  output logic fetch_o
);
  tbl_state_e state_q, state_d;

  always_comb begin
    state_d = ST_IDLE;
    if (state_q == ST_IDLE && req_i) state_d = ST_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign start_o = req_i && (state_q == ST_IDLE);
  assign fetch_o = (state_q == ST_FETCH);

  assert_single_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o);
  assert_start_leads_fetch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> fetch_o);
endmodule

// File: rtl/tbl_lookup.sv
module tbl_lookup
  import tbl_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned NIB_W  = NIB_W_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tabp_i,
  input  logic                      en_set_i,
  input  logic                      bkup_ret_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [NIB_W-1:0]          hi_nib_i,
  input  logic [NIB_W-1:0]          lo_nib_i,
  input  logic [2*NIB_W:0]          rom_rdata_i,
  output logic                      rom_re_o,
  output logic [PAGE_W+2*NIB_W-1:0] rom_addr_o,
  output logic                      stk_push_o,
  output logic                      stk_pop_o,
  output logic                      busy_o,
  output logic                      reg_we_o,
  output logic [NIB_W-1:0]          hi_wdata_o,
  output logic [NIB_W-1:0]          lo_wdata_o,
  output logic                      cy_we_o,
  output logic                      cy_o
);
  localparam int unsigned DATA_W = 2 * NIB_W;
  localparam int unsigned CY_BIT = DATA_W;

  logic start, fetch, cy_en;

  tbl_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (tabp_i),
    .start_o (start),
    .fetch_o (fetch)
  );

  tbl_addr_gen #(.PAGE_W(PAGE_W), .NIB_W(NIB_W)) i_addr (
    .page_i (page_i),
    .hi_i   (hi_nib_i),
    .lo_i   (lo_nib_i),
    .addr_o (rom_addr_o)
  );

  tbl_cy_enable i_cy_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (en_set_i),
    .clr_i  (bkup_ret_i),
    .en_o   (cy_en)
  );

  assign rom_re_o   = start;
  assign stk_push_o = start;
  assign stk_pop_o  = fetch;
  assign busy_o     = fetch;
  assign reg_we_o   = fetch;
  assign lo_wdata_o = rom_rdata_i[NIB_W-1:0];
  assign hi_wdata_o = rom_rdata_i[DATA_W-1:NIB_W];
  assign cy_we_o    = fetch && cy_en;
  assign cy_o       = cy_we_o && rom_rdata_i[CY_BIT];

  assert_push_then_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_push_o |=> (reg_we_o && stk_pop_o));
  assert_no_read_in_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (!rom_re_o && !stk_push_o));
  assert_carry_only_after_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cy_we_o |-> $past(stk_push_o));
  assert_carry_value_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cy_o |-> cy_we_o);
endmodule

// File: tb/test_tbl_lookup.sv
module test_tbl_lookup;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tabp = 1'b0, en_set = 1'b0, bkup = 1'b0;
  logic [5:0]  page = '0;
  logic [3:0]  hi = '0, lo = '0;
  logic [8:0]  rom_q = '0;
  logic        rom_re_o, stk_push_o, stk_pop_o, busy_o, reg_we_o, cy_we_o, cy_o;
  logic [13:0] rom_addr_o;
  logic [3:0]  hi_wdata_o, lo_wdata_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit flag_m = 1'b0;

  always #5 clk = ~clk;

  tbl_lookup i_tbl_lookup (
    .clk_i(clk), .rst_ni(rst_ni), .tabp_i(tabp), .en_set_i(en_set), .bkup_ret_i(bkup),
    .page_i(page), .hi_nib_i(hi), .lo_nib_i(lo), .rom_rdata_i(rom_q),
    .rom_re_o(rom_re_o), .rom_addr_o(rom_addr_o), .stk_push_o(stk_push_o),
    .stk_pop_o(stk_pop_o), .busy_o(busy_o), .reg_we_o(reg_we_o),
    .hi_wdata_o(hi_wdata_o), .lo_wdata_o(lo_wdata_o), .cy_we_o(cy_we_o), .cy_o(cy_o)
  );

  function automatic logic [8:0] rom_fn(input logic [13:0] a);
    logic [31:0] t;
    t = a * 32'd37 ^ (a >> 3) ^ 32'h15A ^ (a >> 7);
    return t[8:0];
  endfunction

  always_ff @(posedge clk) if (rom_re_o) rom_q <= rom_fn(rom_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic upd(input bit s, input bit b);
    if (b) flag_m = 1'b0;
    else if (s) flag_m = 1'b1;
  endtask

  task automatic tab(input logic [5:0] p, input logic [3:0] h, input logic [3:0] l,
                     input bit s0, input bit b0, input bit s1, input bit b1, input bit hold);
    logic [13:0] ea;
    logic [8:0]  w;
    @(negedge clk);
    tabp = 1'b1; page = p; hi = h; lo = l; en_set = s0; bkup = b0;
    #1;
    ea = {p, h, l};
    chk(rom_re_o === 1'b1 && stk_push_o === 1'b1 && busy_o === 1'b0, "R2 issue strobes",
        {rom_re_o, stk_push_o, busy_o}, 3'b110);
    chk(rom_addr_o === ea, "R2 address", rom_addr_o, ea);
    @(posedge clk); upd(s0, b0);
    @(negedge clk);
    tabp = hold; en_set = s1; bkup = b1; page = $urandom; hi = $urandom; lo = $urandom;
    #1;
    w = rom_fn(ea);
    chk(reg_we_o === 1'b1 && stk_pop_o === 1'b1, "R3 write/pop", {reg_we_o, stk_pop_o}, 2'b11);
    chk(lo_wdata_o === w[3:0] && hi_wdata_o === w[7:4], "R3 nibbles",
        {hi_wdata_o, lo_wdata_o}, w[7:0]);
    if (flag_m)
      chk(cy_we_o === 1'b1 && cy_o === w[8], "R4 carry load", {cy_we_o, cy_o}, {1'b1, w[8]});
    else
      chk(cy_we_o === 1'b0 && cy_o === 1'b0, "R5 carry untouched", {cy_we_o, cy_o}, 2'b00);
    chk(busy_o === 1'b1, "R9 busy in write", busy_o, 1);
    if (hold)
      chk(rom_re_o === 1'b0 && stk_push_o === 1'b0, "R9 strobe ignored",
          {rom_re_o, stk_push_o}, 2'b00);
    @(posedge clk); upd(s1, b1);
    @(negedge clk);
    tabp = 1'b0; en_set = 1'b0; bkup = 1'b0;
  endtask

  task automatic idle(input bit s, input bit b);
    @(negedge clk);
    tabp = 1'b0; en_set = s; bkup = b;
    #1;
    chk(rom_re_o === 1'b0 && stk_push_o === 1'b0 && reg_we_o === 1'b0, "R2 quiet without tabp",
        {rom_re_o, stk_push_o, reg_we_o}, 3'b000);
    @(posedge clk); upd(s, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; tabp = 1'b0; en_set = 1'b0; bkup = 1'b0; flag_m = 1'b0;
    #1;
    chk(reg_we_o === 1'b0 && stk_pop_o === 1'b0 && busy_o === 1'b0 && cy_we_o === 1'b0,
        "R1 reset outputs", {reg_we_o, stk_pop_o, busy_o, cy_we_o}, 4'b0000);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    tab(6'h2A, 4'h5, 4'hC, 0, 0, 0, 0, 0);   // R1: flag clear after reset
    tab(6'h3F, 4'hF, 4'hF, 0, 0, 0, 0, 0);   // R5 top address
    tab(6'h00, 4'h0, 4'h0, 0, 0, 0, 0, 0);
    idle(1, 0);                              // R6 set
    tab(6'h11, 4'h3, 4'h9, 0, 0, 0, 0, 0);   // R4
    for (int i = 0; i < 6; i++) idle(0, 0);
    tab(6'h15, 4'hA, 4'h6, 0, 0, 0, 0, 0);   // R8 still set
    idle(1, 1);                              // R7 clear wins
    tab(6'h21, 4'h1, 4'h2, 0, 0, 0, 0, 0);
    tab(6'h05, 4'h7, 4'hE, 1, 0, 0, 0, 0);   // R6 set in issue cycle
    tab(6'h06, 4'h8, 4'h1, 0, 0, 0, 0, 1);   // R9 tabp held in write
    tab(6'h07, 4'h9, 4'h4, 0, 0, 0, 1, 0);   // R7 clear during write
    tab(6'h08, 4'h2, 4'hB, 0, 0, 0, 0, 0);
    idle(1, 0);
    do_reset();                              // R1 mid-run reset clears flag
    tab(6'h09, 4'hC, 4'h3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 6)
        tab($urandom, $urandom, $urandom, ($urandom_range(0, 7) == 0), ($urandom_range(0, 11) == 0),
            ($urandom_range(0, 7) == 0), ($urandom_range(0, 11) == 0), ($urandom_range(0, 3) == 0));
      else
        idle(($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule